// File: doc/BRIEF.md
# Integer Minimum/Maximum Unit with Condition Field

This block picks the smaller or the larger of two register-width integer operands and, on request, records how the two operands compare as a small condition field. A three-bit mode selects the comparison width (full doubleword or the low word), the ordering (unsigned or two's-complement signed), and whether the minimum or the maximum is kept. A flag tells the unit that the first operand's register index was zero, in which case that operand reads as the constant zero.

All eight variants run through one unsigned magnitude comparator. For word mode the low half of each operand is moved into the upper half with zeros below. For signed mode the top bit of each comparison key is flipped. The value written out is always the whole, untouched source operand that won, even when only its low half took part in the comparison. The result and the condition field are registered once, so they appear at the clock edge after the inputs.

When the record input is set, the unit also drives a four-bit condition field: a one-hot less/greater/equal code followed by a copy of the incoming summary-overflow bit, together with a write enable.

Top module: `minmax_unit`

## Requirements
- R1: While rst_ni is low, result_o, cr_o and cr_we_o are all zero.
- R2: mode_i[2] set selects word width, mode_i[1] set selects signed ordering, mode_i[0] set selects maximum; with mode_i[2:1]=00 the unit returns the unsigned minimum (mode_i[0]=0) or maximum (mode_i[0]=1) of the full-width operands.
- R3: With mode_i[1] set the ordering is two's-complement signed over the compared width.
- R4: With mode_i[2] set only the low XLEN/2 bits of each operand are compared, and the full XLEN-bit winning operand is returned unchanged.
- R5: With ra_zero_i set, operand A is the constant zero for both the comparison and the returned value.
- R6: When the compared keys are equal, the B operand is returned.
- R7: With rc_i set, cr_o[3:1] is 3'b100 when A orders below B, 3'b010 when A orders above B and 3'b001 when equal, independent of mode_i[0]; cr_o[0] equals so_i.
- R8: cr_we_o equals rc_i; with rc_i clear, cr_o is zero.
- R9: Every output reflects the inputs present at the previous rising clock edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | XLEN | Operand A register value |
| b_i | input | XLEN | Operand B register value |
| ra_zero_i | input | 1 | A register index is zero; A reads as 0 |
| mode_i | input | 3 | [2] word, [1] signed, [0] max |
| rc_i | input | 1 | Record condition field |
| so_i | input | 1 | Incoming summary-overflow bit |
| result_o | output | XLEN | Selected source operand |
| cr_o | output | 4 | {lt, gt, eq, so} condition field |
| cr_we_o | output | 1 | Condition field write enable |

## Verification
A narrow four-bit build is swept over every pair of operands in all eight modes, with and without the zero-A flag, so that equal keys, sign-boundary pairs (where signed and unsigned order disagree) and pairs whose upper halves differ while their low halves match (which split word mode from doubleword mode) all occur. The record and summary-overflow inputs are varied across the sweep so each comparison outcome is seen both with and without a condition write. A full-width build then takes directed vectors whose upper halves would reverse the answer if word mode compared them, and a signed doubleword maximum across the most negative value.

// File: rtl/minmax_pkg.sv
package minmax_pkg;
  localparam int MODE_W = 3;
  localparam int CR_W   = 4;

  typedef struct packed {
    logic word;
    logic signd;
    logic is_max;
  } mm_mode_t;

  localparam logic [2:0] CC_LT = 3'b100;
  localparam logic [2:0] CC_GT = 3'b010;
  localparam logic [2:0] CC_EQ = 3'b001;
endpackage

// File: rtl/minmax_xform.sv
module minmax_xform #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] op_i,
  input  logic            word_i,
  input  logic            signd_i,
  output logic [XLEN-1:0] key_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] placed;

  always_comb begin
    placed = word_i ? {op_i[HALF-1:0], {HALF{1'b0}}} : op_i;
    key_o  = placed;
    // flipped top bit turns unsigned order into signed order
    key_o[XLEN-1] = placed[XLEN-1] ^ signd_i;
  end
endmodule

// File: rtl/minmax_cmp.sv
module minmax_cmp #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] l_i,
  input  logic [XLEN-1:0] r_i,
  output logic            lt_o,
  output logic            eq_o
);
  assign lt_o = l_i < r_i;
  assign eq_o = l_i == r_i;
endmodule

// File: rtl/minmax_unit.sv
module minmax_unit
  import minmax_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  input  logic              ra_zero_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              rc_i,
  input  logic              so_i,
  output logic [XLEN-1:0]   result_o,
  output logic [CR_W-1:0]   cr_o,
  output logic              cr_we_o
);
  localparam int NOPS = 2;

  mm_mode_t        mode;
  logic [XLEN-1:0] src [NOPS];
  logic [XLEN-1:0] key [NOPS];
  logic            lt_ab, eq_ab, gt_ab, take_a;
  logic [2:0]      cc;
  logic [XLEN-1:0] result_d;
  logic [CR_W-1:0] cr_d;

  assign mode   = mm_mode_t'(mode_i);
  assign src[0] = ra_zero_i ? '0 : a_i;
  assign src[1] = b_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_xform
    minmax_xform #(.XLEN(XLEN)) u_xform (
      .op_i    (src[g]),
      .word_i  (mode.word),
      .signd_i (mode.signd),
      .key_o   (key[g])
    );
  end

  minmax_cmp #(.XLEN(XLEN)) u_cmp (
    .l_i  (key[0]),
    .r_i  (key[1]),
    .lt_o (lt_ab),
    .eq_o (eq_ab)
  );

  assign gt_ab  = ~lt_ab & ~eq_ab;
  // max swaps the sense of the ordering; ties fall to B
  assign take_a = mode.is_max ? gt_ab : lt_ab;

  always_comb begin
    result_d = take_a ? src[0] : src[1];
    cc       = lt_ab ? CC_LT : (gt_ab ? CC_GT : CC_EQ);
    cr_d     = rc_i ? {cc, so_i} : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      cr_o     <= '0;
      cr_we_o  <= 1'b0;
    end else begin
      result_o <= result_d;
      cr_o     <= cr_d;
      cr_we_o  <= rc_i;
    end
  end
endmodule

// File: rtl/minmax_unit_chk.sv
module minmax_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] a_i,
  input logic [XLEN-1:0] b_i,
  input logic            ra_zero_i,
  input logic            rc_i,
  input logic            so_i,
  input logic [XLEN-1:0] result_o,
  input logic [3:0]      cr_o,
  input logic            cr_we_o
);
  logic [XLEN-1:0] a_eff;
  assign a_eff = ra_zero_i ? '0 : a_i;

  a_r8_we_tracks_rc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cr_we_o == $past(rc_i));

  a_r8_cr_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rc_i |=> cr_o == 4'b0000);

  a_r7_code_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rc_i |=> $countones(cr_o[3:1]) == 1);

  a_r7_so_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rc_i |=> cr_o[0] == $past(so_i));

  a_r4_whole_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (result_o == $past(a_eff)) || (result_o == $past(b_i)));

  a_r6_equal_gives_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_eff == b_i) |=> result_o == $past(b_i));

  a_r5_zero_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ra_zero_i |=> (result_o == '0) || (result_o == $past(b_i)));
endmodule

bind minmax_unit minmax_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .a_i       (a_i),
  .b_i       (b_i),
  .ra_zero_i (ra_zero_i),
  .rc_i      (rc_i),
  .so_i      (so_i),
  .result_o  (result_o),
  .cr_o      (cr_o),
  .cr_we_o   (cr_we_o)
);

// File: tb/tb_minmax_unit.sv
`timescale 1ns/1ps
module tb_minmax_unit;
  localparam int W  = 4;
  localparam int WL = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  a = '0, b = '0;
  logic          rz = 1'b0, rc = 1'b0, so = 1'b0;
  logic [2:0]    mode = '0;
  logic [W-1:0]  res;
  logic [3:0]    cr;
  logic          we;

  logic [WL-1:0] la = '0, lb = '0;
  logic          lrz = 1'b0, lrc = 1'b0, lso = 1'b0;
  logic [2:0]    lmode = '0;
  logic [WL-1:0] lres;
  logic [3:0]    lcr;
  logic          lwe;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  minmax_unit #(.XLEN(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .ra_zero_i(rz),
    .mode_i(mode), .rc_i(rc), .so_i(so),
    .result_o(res), .cr_o(cr), .cr_we_o(we)
  );

  minmax_unit #(.XLEN(WL)) dut_w (
    .clk_i(clk), .rst_ni(rst_n), .a_i(la), .b_i(lb), .ra_zero_i(lrz),
    .mode_i(lmode), .rc_i(lrc), .so_i(lso),
    .result_o(lres), .cr_o(lcr), .cr_we_o(lwe)
  );

  task automatic check(input string tag, input logic [WL-1:0] act, input logic [WL-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string res_tag(input logic [2:0] m, input logic z, input logic eqk);
    if (eqk)       return "R6";
    if (m[2])      return "R4";
    if (z)         return "R5";
    if (m[1])      return "R3";
    return "R2";
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // R1: reset values
    a = 4'hF; b = 4'h3; rc = 1'b1; so = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 result", WL'(res), '0);
    check("R1 cr", WL'(cr), '0);
    check("R1 we", WL'(we), '0);
    rst_n = 1'b1;

    // R9: outputs are sampled one edge after the inputs are applied
    for (int m = 0; m < 8; m++) begin
      for (int z = 0; z < 2; z++) begin
        for (int ia = 0; ia < 16; ia++) begin
          for (int ib = 0; ib < 16; ib++) begin
            logic [W-1:0] av, er;
            logic [2:0]   cc;
            logic [3:0]   ecr;
            int ka, kb;
            logic lt, gt, pick;
            a = W'(ia); b = W'(ib); mode = 3'(m); rz = z[0];
            rc = ^{a, b, mode, rz};
            so = a[1] ^ b[0];
            av = rz ? '0 : a;
            if (mode[2]) begin
              ka = mode[1] ? int'($signed(av[1:0])) : int'(av[1:0]);
              kb = mode[1] ? int'($signed(b[1:0]))  : int'(b[1:0]);
            end else begin
              ka = mode[1] ? int'($signed(av)) : int'(av);
              kb = mode[1] ? int'($signed(b))  : int'(b);
            end
            lt = ka < kb;
            gt = ka > kb;
            cc = lt ? 3'b100 : (gt ? 3'b010 : 3'b001);
            pick = mode[0] ? gt : lt;
            er = pick ? av : b;
            ecr = rc ? {cc, so} : 4'b0000;
            @(posedge clk);
            @(negedge clk);
            check($sformatf("%s R9 result m=%0d z=%0d a=%0h b=%0h",
                  res_tag(mode, rz, ka == kb), mode, rz, a, b), WL'(res), WL'(er));
            check(rc ? "R7 cr" : "R8 cr", WL'(cr), WL'(ecr));
            check("R8 we", WL'(we), WL'(rc));
          end
        end
      end
    end

    // R4: upper halves would reverse the answer if they were compared
    la = 64'hFFFF_FFFF_0000_0001; lb = 64'h0000_0000_FFFF_FFFF;
    lmode = 3'b100; lrc = 1'b1; lso = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R4 wide word unsigned min", lres, 64'hFFFF_FFFF_0000_0001);
    check("R7 wide cr lt", WL'(lcr), WL'(4'b1001));

    // R3 R4: signed word, low half of B is -1
    lmode = 3'b110; lso = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R3 wide word signed min", lres, 64'h0000_0000_FFFF_FFFF);
    check("R7 wide cr gt", WL'(lcr), WL'(4'b0100));

    // R3: signed doubleword max across most negative value
    la = 64'h8000_0000_0000_0000; lb = 64'h1;
    lmode = 3'b011; lrc = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R3 wide dword signed max", lres, 64'h1);
    check("R8 wide cr clear", WL'(lcr), '0);
    check("R8 wide we", WL'(lwe), '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule